// File: doc/BRIEF.md
# SPI Slave Transmit Path with Burst Padding

This block is the transmit half of an SPI slave. It takes bytes from a small FIFO, fed either by software or by a DMA channel through one byte-wide push port, and shifts them out on MISO, most significant bit first, in SPI mode 0. SCLK and the active-low slave select are sampled by the block's own clock. The inputs are assumed to be synchronous to that clock already, and each SCLK level lasts several clock cycles.

The FIFO needs time to hand a freshly pushed byte to the shifter. To allow for this, the block puts one padding byte in front of each new burst. Padding is armed in a select window only after the receive side has reported a valid byte. Once armed, any push into an empty FIFO queues one padding byte ahead of the pushed data. A configuration input picks the padding value: either all ones, or a repeat of the last byte sent in the window. If the shifter needs a byte while the FIFO is empty and no padding is queued, it sends the same padding value as filler.

Top module: `spi_pad_tx`

## Requirements
- R1: After reset, tx_empty is 1, tx_full is 0 and miso is 0.
- R2: Bytes leave MSB first. The first byte of a window is loaded when nssel is seen low. Each later byte is loaded on the 8th rising SCLK edge of the byte before it. MISO shifts on falling SCLK edges inside a byte.
- R3: The FIFO holds 4 bytes. tx_full is 1 when it holds 4, and tx_empty is 1 when it holds none. A push while it is full is dropped, and the stored bytes stay unchanged.
- R4: Padding is armed only when rx_valid is 1 while nssel is 0. If rx_valid is 1 while nssel is 1, nothing is armed.
- R5: Once armed, a push into an empty FIFO causes exactly one padding byte to go out before the pushed byte. A push into a non-empty FIFO adds no padding.
- R6: If pad_repeat is 0, the padding value is 0xFF. If pad_repeat is 1, it is the last byte loaded into the shifter in the current window, or 0x00 if no byte has been loaded yet.
- R7: When nssel goes high, the arming, any queued padding and the last-byte value are all cleared.
- R8: When a byte is needed, the FIFO is empty and no padding is queued, the padding value is sent as filler and the FIFO is left untouched.
- R9: miso is 0 while nssel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock from the master, synchronous to clk |
| nssel | input | 1 | Active-low slave select |
| rx_valid | input | 1 | Receive-FIFO-not-empty status from the receive side |
| pad_repeat | input | 1 | Padding value select: 0 gives 0xFF, 1 repeats the last byte |
| push | input | 1 | Write strobe into the transmit FIFO |
| push_data | input | 8 | Byte to write |
| miso | output | 1 | Serial data to the master |
| tx_full | output | 1 | FIFO holds 4 bytes |
| tx_empty | output | 1 | FIFO holds no bytes |

## Verification
The bench pushes the second byte of a burst while the first is still shifting. It then checks that one padding byte appears in front of it only when the window is armed. A block that pads unconditionally, or never pads, would shift the data by one byte position. A two-byte burst shows whether padding is inserted once per burst or once per push. Repeat-mode padding right after a new select shows whether the last-byte register survived the deselect, and a window without rx_valid shows whether the arming leaked across windows. A fifth push into a full FIFO must not displace a stored byte.

// File: rtl/spi_pad_pkg.sv
package spi_pad_pkg;
    // Where the next byte for the shifter comes from
    typedef enum logic [1:0] {
        SRC_FIFO = 2'd0,
        SRC_PAD  = 2'd1,
        SRC_FILL = 2'd2
    } byte_src_e;
endpackage

// File: rtl/spi_pad_fifo.sv
module spi_pad_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty,
    output logic         push_acc
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [AW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic pop_acc;

    assign full     = (st_q.cnt == (AW+1)'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign head     = st_q.mem[st_q.rd];
    assign push_acc = push & ~full;
    assign pop_acc  = pop & ~empty;

    always_comb begin
        st_d = st_q;
        if (push_acc) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr           = st_q.wr + 1'b1;
        end
        if (pop_acc) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        case ({push_acc, pop_acc})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_pad_ser.sv
module spi_pad_ser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         sel_fall,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic [W-1:0] load_byte,
    output logic         load_req,
    output logic         bit_out
);
    localparam int CW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    last_edge;

    assign last_edge = active & sclk_rise & (st_q.cnt == CW'(W-1));
    assign load_req  = sel_fall | last_edge;
    assign bit_out   = st_q.sh[W-1];

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.cnt = '0;
        end else if (sclk_rise) begin
            st_d.cnt = (st_q.cnt == CW'(W-1)) ? '0 : st_q.cnt + 1'b1;
        end
        if (load_req) begin
            st_d.sh = load_byte;
        end else if (active && sclk_fall && (st_q.cnt != '0)) begin
            st_d.sh = {st_q.sh[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_pad_arm.sv
module spi_pad_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic nssel,
    input  logic rx_valid,
    input  logic fifo_empty,
    input  logic push_acc,
    input  logic pad_taken,
    output logic armed,
    output logic pad_pend
);
    typedef struct packed {
        logic armed;
        logic pend;
    } arm_st_t;

    arm_st_t st_d, st_q;

    assign armed    = st_q.armed;
    assign pad_pend = st_q.pend;

    always_comb begin
        st_d = st_q;
        if (nssel) begin
            st_d.armed = 1'b0;
            st_d.pend  = 1'b0;
        end else begin
            st_d.armed = st_q.armed | rx_valid;
            st_d.pend  = (st_q.pend & ~pad_taken)
                       | (st_q.armed & push_acc & fifo_empty);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_pad_tx.sv
module spi_pad_tx #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         nssel,
    input  logic         rx_valid,
    input  logic         pad_repeat,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         miso,
    output logic         tx_full,
    output logic         tx_empty
);
    import spi_pad_pkg::*;

    typedef struct packed {
        logic         sclk;
        logic         nssel;
        logic [W-1:0] last;
    } top_st_t;

    top_st_t   st_d, st_q;
    byte_src_e src;
    logic      sclk_rise, sclk_fall, sel_fall;
    logic      load_req, ser_bit, fifo_pop, pad_taken, push_acc;
    logic      armed, pad_pend;
    logic [W-1:0] head, pad_val, load_byte;

    assign sclk_rise = sclk & ~st_q.sclk;
    assign sclk_fall = ~sclk & st_q.sclk;
    assign sel_fall  = ~nssel & st_q.nssel;

    assign pad_val = pad_repeat ? st_q.last : {W{1'b1}};

    always_comb begin
        if (pad_pend)       src = SRC_PAD;
        else if (!tx_empty) src = SRC_FIFO;
        else                src = SRC_FILL;
    end

    assign load_byte = (src == SRC_FIFO) ? head : pad_val;
    assign fifo_pop  = load_req & (src == SRC_FIFO);
    assign pad_taken = load_req & (src == SRC_PAD);
    assign miso      = ~nssel & ser_bit;

    always_comb begin
        st_d       = st_q;
        st_d.sclk  = sclk;
        st_d.nssel = nssel;
        if (nssel)         st_d.last = '0;
        else if (load_req) st_d.last = load_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.nssel <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    spi_pad_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_data),
        .pop(fifo_pop), .head(head), .full(tx_full), .empty(tx_empty),
        .push_acc(push_acc)
    );

    spi_pad_arm u_arm (
        .clk(clk), .rst_n(rst_n), .nssel(nssel), .rx_valid(rx_valid),
        .fifo_empty(tx_empty), .push_acc(push_acc), .pad_taken(pad_taken),
        .armed(armed), .pad_pend(pad_pend)
    );

    spi_pad_ser #(.W(W)) u_ser (
        .clk(clk), .rst_n(rst_n), .active(~nssel), .sel_fall(sel_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .load_byte(load_byte),
        .load_req(load_req), .bit_out(ser_bit)
    );
endmodule

// File: rtl/spi_pad_tx_chk.sv
module spi_pad_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic nssel,
    input logic rx_valid,
    input logic push,
    input logic miso,
    input logic tx_full,
    input logic tx_empty,
    input logic armed,
    input logic pad_pend,
    input logic fifo_pop
);
    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    // R3
    push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && push && !fifo_pop) |=> tx_full);

    // R4
    arm_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(rx_valid) && !$past(nssel)));

    // R5
    pend_only_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pend |-> armed);

    // R7
    deselect_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nssel |=> (!armed && !pad_pend));

    // R9
    miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nssel |-> !miso);
endmodule

bind spi_pad_tx spi_pad_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nssel(nssel), .rx_valid(rx_valid),
    .push(push), .miso(miso), .tx_full(tx_full), .tx_empty(tx_empty),
    .armed(armed), .pad_pend(pad_pend), .fifo_pop(fifo_pop)
);

// File: tb/spi_pad_tx_test.sv
module spi_pad_tx_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, nssel = 1'b1, rx_valid = 1'b0, pad_repeat = 1'b0;
    logic push = 1'b0;
    logic [7:0] push_data = '0;
    logic miso, tx_full, tx_empty;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_pad_tx uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .nssel(nssel),
        .rx_valid(rx_valid), .pad_repeat(pad_repeat), .push(push),
        .push_data(push_data), .miso(miso), .tx_full(tx_full),
        .tx_empty(tx_empty)
    );

    typedef struct packed {
        logic       rpt;
        logic       arm;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] e1;
        logic [7:0] e2;
    } vec_t;

    // Window: d0 preloaded, select, optional rx_valid, push d1 during byte 0.
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 8'hA5, 8'h3C, 8'hFF, 8'h3C},
        '{1'b1, 1'b1, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
        '{1'b0, 1'b0, 8'hA5, 8'h3C, 8'h3C, 8'hFF},
        '{1'b1, 1'b0, 8'h12, 8'h80, 8'h80, 8'h80},
        '{1'b1, 1'b1, 8'h00, 8'hFF, 8'h00, 8'hFF},
        '{1'b0, 1'b1, 8'h7E, 8'h81, 8'hFF, 8'h81}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_push(input logic [7:0] d);
        @(negedge clk);
        push = 1'b1;
        push_data = d;
        @(negedge clk);
        push = 1'b0;
    endtask

    task automatic pulse_rx();
        @(negedge clk);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic select();
        @(negedge clk);
        nssel = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic deselect();
        @(negedge clk);
        nssel = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic xfer(output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            wait_clk(HALF);
            b = {b[6:0], miso};
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    initial begin
        wait_clk(150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] b;
        wait_clk(3);
        // R1 reset state
        check("R1 empty", {7'b0, tx_empty}, 8'h01);
        check("R1 full", {7'b0, tx_full}, 8'h00);
        check("R1 miso", {7'b0, miso}, 8'h00);
        rst_n = 1'b1;
        wait_clk(2);

        // Vector table: R2 R5 R6 R8
        foreach (VECS[k]) begin
            pad_repeat = VECS[k].rpt;
            do_push(VECS[k].d0);
            select();
            if (VECS[k].arm) pulse_rx();
            do_push(VECS[k].d1);
            xfer(b); check("R2 first byte", b, VECS[k].d0);
            xfer(b); check("R5 R6 second byte", b, VECS[k].e1);
            xfer(b); check("R8 third byte", b, VECS[k].e2);
            deselect();
            // R9 miso quiet while deselected
            check("R9 miso idle", {7'b0, miso}, 8'h00);
        end

        // R3 full flag and dropped push
        pad_repeat = 1'b0;
        do_push(8'h01); do_push(8'h02); do_push(8'h03);
        check("R3 not full at 3", {7'b0, tx_full}, 8'h00);
        do_push(8'h04);
        check("R3 full at 4", {7'b0, tx_full}, 8'h01);
        do_push(8'hEE);
        check("R3 still full", {7'b0, tx_full}, 8'h01);
        select();
        xfer(b); check("R3 byte0", b, 8'h01);
        xfer(b); check("R3 byte1", b, 8'h02);
        xfer(b); check("R3 byte2", b, 8'h03);
        xfer(b); check("R3 byte3", b, 8'h04);
        xfer(b); check("R3 R8 dropped push not sent", b, 8'hFF);
        check("R3 empty after drain", {7'b0, tx_empty}, 8'h01);
        deselect();

        // R5 one padding byte per burst; R6 repeat of zero at window start
        pad_repeat = 1'b1;
        select();
        pulse_rx();
        do_push(8'h11);
        do_push(8'h22);
        xfer(b); check("R6 R8 fill at start", b, 8'h00);
        xfer(b); check("R5 single pad", b, 8'h00);
        xfer(b); check("R5 burst byte a", b, 8'h11);
        xfer(b); check("R5 burst byte b", b, 8'h22);
        xfer(b); check("R6 R8 repeat fill", b, 8'h22);
        deselect();

        // R7 clearing at deselect; R4 rx_valid while deselected ignored
        do_push(8'h5A);
        select();
        pulse_rx();
        xfer(b); check("R7 window A byte", b, 8'h5A);
        xfer(b); check("R6 window A repeat", b, 8'h5A);
        deselect();
        pulse_rx();
        select();
        do_push(8'h77);
        xfer(b); check("R7 last cleared", b, 8'h00);
        xfer(b); check("R4 R7 no pad when unarmed", b, 8'h77);
        deselect();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule